// File: doc/BRIEF.md
# Multi-Class Interrupt Pending Store and Prioritizer

This block keeps the interrupts that are waiting for one processor thread. There are seven classes: trap level zero, hypervisor timer match, external interrupt vector, cross-CPU message, device message, software interrupt and resumable error. Each class has its own 64-bit pending vector. A post port sets one bit and a clear port resets one bit, each addressed by a class number and a bit index. A clear-all input empties everything at once. A per-class summary word shows which classes hold at least one pending bit, and any class vector can be read back through a combinational read port.

From the registered vectors, the current privilege mode (hypervisor or not) and the interrupt-enable bit, the block picks the class to deliver next. It reports that class as a 3-bit code with a valid flag. It also encodes the software-interrupt vector into a priority level. Delivering an interrupt does not remove it. The surrounding core has to clear the bit explicitly once the handler has dealt with the source.

Top module: `intr_pend_prio`

## Requirements
- R1: Class codes are TLZERO=0, HVTICK=1, VECTOR=2, XCPU=3, DEVMSG=4, SOFT=5, RESERR=6. A post with `post_en`=1 sets bit `post_idx` of class `post_cls` at the next rising clock edge. `rd_vec` shows the vector of class `rd_cls` combinationally.
- R2: A clear with `clr_en`=1 resets bit `clr_idx` of class `clr_cls`. Bit c of `pend_sum` stays 1 while any bit of class c's vector is still set, and it drops only when that vector becomes all zero.
- R3: `any_pend` is 1 exactly when `pend_sum` is nonzero. A posted bit appears in `pend_sum` at the same edge as in the vector.
- R4: `clr_all`=1 zeroes every vector and `pend_sum` at the next edge. It overrides a post or clear in the same cycle.
- R5: With `hv_mode`=1, nothing is selected unless `int_en`=1. With `int_en`=1, HVTICK is chosen before VECTOR, and no other class is ever selected.
- R6: With `hv_mode`=0, the order TLZERO, HVTICK, VECTOR applies whatever the value of `int_en`.
- R7: With `hv_mode`=0 and `int_en`=1, the classes below VECTOR follow in the order XCPU, DEVMSG, SOFT, RESERR. With `int_en`=0 these four are never selected.
- R8: `soft_lvl` is 14 when bit 16 or bit 0 of the SOFT vector is set. Otherwise it is the index of the highest set bit among bits 15..1, or 0 when none of those bits is set. Bits above 16 never affect it.
- R9: Selecting a class leaves every vector unchanged. Pending bits go away only through a clear or clear-all.
- R10: A post and a clear that address the same bit in the same cycle leave that bit set.
- R11: A post or clear with class number 7 changes nothing. Reading class 7 returns zero.
- R12: While `rst_n` is low, all vectors and `pend_sum` are zero, `sel_valid` is 0 and `sel_code` is 7 (none). `sel_code` is also 7 whenever nothing qualifies.

Several requirements can be exercised without reading any internal state:
- R2 and R10 are both visible on `rd_vec` and `pend_sum`.
- R9 is visible because `rd_vec` and `sel_code` do not change while the same selection is held for several cycles.
- R11 is visible because `any_pend` and `rd_vec` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_en | input | 1 | Post strobe |
| post_cls | input | 3 | Class of the bit to post |
| post_idx | input | 6 | Index of the bit to post |
| clr_en | input | 1 | Clear strobe |
| clr_cls | input | 3 | Class of the bit to clear |
| clr_idx | input | 6 | Index of the bit to clear |
| clr_all | input | 1 | Empty every vector |
| hv_mode | input | 1 | Hypervisor privilege mode |
| int_en | input | 1 | Interrupt enable |
| rd_cls | input | 3 | Class to read back |
| rd_vec | output | 64 | Pending vector of `rd_cls` |
| pend_sum | output | 7 | Per-class nonempty flags |
| any_pend | output | 1 | Some class is pending |
| sel_valid | output | 1 | A class qualifies for delivery |
| sel_code | output | 3 | Selected class code, 7 when none |
| soft_lvl | output | 4 | Encoded software-interrupt level |

## Verification
The post and clear ports can both act in the same cycle. Two cases matter. When both address the same bit, the post must win. When they address different bits of one class, the summary bit must reflect the combined result. A clear-all arriving together with a post is a further collision, and the clear-all must win. The bench drives these pairs in a single cycle and judges the result through `rd_vec` and `pend_sum` after the next edge.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int NUM_CLASSES = 7;
  localparam int CLS_W       = 3;
  localparam int VEC_W       = 64;
  localparam int IDX_W       = $clog2(VEC_W);
  localparam int LVL_W       = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_TLZERO = 3'd0,
    CLS_HVTICK = 3'd1,
    CLS_VECTOR = 3'd2,
    CLS_XCPU   = 3'd3,
    CLS_DEVMSG = 3'd4,
    CLS_SOFT   = 3'd5,
    CLS_RESERR = 3'd6,
    CLS_NONE   = 3'd7
  } cls_e;
endpackage

// File: rtl/intr_vec_bank.sv
module intr_vec_bank #(
  parameter int VEC_W = 64,
  parameter int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_hit,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             clr_hit,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  output logic [VEC_W-1:0] vec_q,
  output logic             nonempty_q
);
  logic [VEC_W-1:0] vec_d;
  logic             upd_en;

  // Next state: clear first, then post (post wins), clear-all overrides all.
  always_comb begin
    vec_d = vec_q;
    if (clr_hit)  vec_d[clr_idx]  = 1'b0;
    if (post_hit) vec_d[post_idx] = 1'b1;
    if (clr_all)  vec_d = '0;
  end

  assign upd_en = post_hit | clr_hit | clr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q      <= '0;
      nonempty_q <= 1'b0;
    end else if (upd_en) begin
      vec_q      <= vec_d;
      nonempty_q <= |vec_d;
    end
  end

  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (post_hit && !clr_all) |=> vec_q[$past(post_idx)]); // R10
  AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !clr_all && !(post_hit && post_idx == clr_idx)) |=> !vec_q[$past(clr_idx)]); // R2
  AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vec_q == '0 && !nonempty_q)); // R4
  AST_HOLD_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(post_hit || clr_hit || clr_all) |=> $stable(vec_q)); // R9
  AST_SUM_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    nonempty_q == (vec_q != '0)); // R2
endmodule

// File: rtl/intr_soft_level.sv
module intr_soft_level #(
  parameter int VEC_W = 64,
  parameter int LVL_W = 4
) (
  input  logic [VEC_W-1:0] soft_vec,
  output logic [LVL_W-1:0] level
);
  localparam int TOP_BIT   = 15;
  localparam int ALIAS_HI  = 16;
  localparam int ALIAS_LO  = 0;
  localparam int ALIAS_LVL = 14;

  always_comb begin
    level = '0;
    for (int i = 1; i <= TOP_BIT; i++) begin
      if (soft_vec[i]) level = LVL_W'(i);
    end
    if (soft_vec[ALIAS_HI] || soft_vec[ALIAS_LO]) level = LVL_W'(ALIAS_LVL);
  end
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
  import intr_pkg::*;
#(
  parameter int NCLS = NUM_CLASSES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] pend,
  input  logic            hv_mode,
  input  logic            int_en,
  output logic            sel_valid,
  output cls_e            sel_code
);
  logic [2**CLS_W-1:0] pend_ext;
  assign pend_ext = {{(2**CLS_W-NCLS){1'b0}}, pend};

  always_comb begin
    sel_code = CLS_NONE;
    if (hv_mode) begin
      if (int_en) begin
        if (pend_ext[CLS_HVTICK])      sel_code = CLS_HVTICK;
        else if (pend_ext[CLS_VECTOR]) sel_code = CLS_VECTOR;
      end
    end else begin
      if (pend_ext[CLS_TLZERO])                sel_code = CLS_TLZERO;
      else if (pend_ext[CLS_HVTICK])           sel_code = CLS_HVTICK;
      else if (pend_ext[CLS_VECTOR])           sel_code = CLS_VECTOR;
      else if (int_en) begin
        if (pend_ext[CLS_XCPU])                sel_code = CLS_XCPU;
        else if (pend_ext[CLS_DEVMSG])         sel_code = CLS_DEVMSG;
        else if (pend_ext[CLS_SOFT])           sel_code = CLS_SOFT;
        else if (pend_ext[CLS_RESERR])         sel_code = CLS_RESERR;
      end
    end
  end

  assign sel_valid = (sel_code != CLS_NONE);

  AST_HV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_mode && !int_en) |-> !sel_valid); // R5
  AST_SEL_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> pend_ext[sel_code]); // R3
  AST_TLZ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_mode && pend_ext[CLS_TLZERO]) |-> (sel_code == CLS_TLZERO)); // R6
  AST_USER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_mode && !int_en && sel_valid) |-> (sel_code <= CLS_VECTOR)); // R7
endmodule

// File: rtl/intr_pend_prio.sv
module intr_pend_prio
  import intr_pkg::*;
#(
  parameter int VEC_W = intr_pkg::VEC_W,
  parameter int NCLS  = intr_pkg::NUM_CLASSES,
  parameter int LVL_W = intr_pkg::LVL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   post_en,
  input  logic [CLS_W-1:0]       post_cls,
  input  logic [$clog2(VEC_W)-1:0] post_idx,
  input  logic                   clr_en,
  input  logic [CLS_W-1:0]       clr_cls,
  input  logic [$clog2(VEC_W)-1:0] clr_idx,
  input  logic                   clr_all,
  input  logic                   hv_mode,
  input  logic                   int_en,
  input  logic [CLS_W-1:0]       rd_cls,
  output logic [VEC_W-1:0]       rd_vec,
  output logic [NCLS-1:0]        pend_sum,
  output logic                   any_pend,
  output logic                   sel_valid,
  output logic [CLS_W-1:0]       sel_code,
  output logic [LVL_W-1:0]       soft_lvl
);
  localparam int IW    = $clog2(VEC_W);
  localparam int SLOTS = 2**CLS_W;

  logic [VEC_W-1:0] vec_arr [SLOTS];
  cls_e             sel_e;

  for (genvar c = 0; c < SLOTS; c++) begin : g_cls
    if (c < NCLS) begin : g_live
      logic post_hit, clr_hit;
      assign post_hit = post_en && (post_cls == CLS_W'(c));
      assign clr_hit  = clr_en  && (clr_cls  == CLS_W'(c));
      intr_vec_bank #(.VEC_W(VEC_W), .IDX_W(IW)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_hit   (post_hit),
        .post_idx   (post_idx),
        .clr_hit    (clr_hit),
        .clr_idx    (clr_idx),
        .clr_all    (clr_all),
        .vec_q      (vec_arr[c]),
        .nonempty_q (pend_sum[c])
      );
    end else begin : g_unused
      assign vec_arr[c] = '0;
    end
  end

  assign rd_vec   = vec_arr[rd_cls];
  assign any_pend = |pend_sum;

  intr_soft_level #(.VEC_W(VEC_W), .LVL_W(LVL_W)) soft_i (
    .soft_vec (vec_arr[CLS_SOFT]),
    .level    (soft_lvl)
  );

  intr_prio_sel #(.NCLS(NCLS)) prio_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_sum),
    .hv_mode   (hv_mode),
    .int_en    (int_en),
    .sel_valid (sel_valid),
    .sel_code  (sel_e)
  );
  assign sel_code = sel_e;

  AST_NONE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |-> (!sel_valid && sel_code == CLS_NONE)); // R12
  AST_BAD_CLASS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && post_cls == CLS_NONE && !clr_en && !clr_all) |=> $stable(pend_sum)); // R11
endmodule

// File: tb/intr_pend_prio_tb_top.sv
module intr_pend_prio_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_en, clr_en, clr_all, hv_mode, int_en;
  logic [2:0]  post_cls, clr_cls, rd_cls;
  logic [5:0]  post_idx, clr_idx;
  logic [63:0] rd_vec;
  logic [6:0]  pend_sum;
  logic        any_pend, sel_valid;
  logic [2:0]  sel_code;
  logic [3:0]  soft_lvl;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  intr_pend_prio dut_i (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_cls(post_cls), .post_idx(post_idx),
    .clr_en(clr_en), .clr_cls(clr_cls), .clr_idx(clr_idx), .clr_all(clr_all),
    .hv_mode(hv_mode), .int_en(int_en), .rd_cls(rd_cls), .rd_vec(rd_vec),
    .pend_sum(pend_sum), .any_pend(any_pend), .sel_valid(sel_valid),
    .sel_code(sel_code), .soft_lvl(soft_lvl)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic pe, input logic [2:0] pc, input logic [5:0] pi,
                    input logic ce, input logic [2:0] cc, input logic [5:0] ci,
                    input logic ca);
    @(negedge clk);
    post_en = pe; post_cls = pc; post_idx = pi;
    clr_en = ce; clr_cls = cc; clr_idx = ci; clr_all = ca;
    @(negedge clk);
    post_en = 0; clr_en = 0; clr_all = 0;
    #1;
  endtask

  task automatic post(input logic [2:0] c, input logic [5:0] i);
    op(1, c, i, 0, 0, 0, 0);
  endtask
  task automatic clear(input logic [2:0] c, input logic [5:0] i);
    op(0, 0, 0, 1, c, i, 0);
  endtask
  task automatic wipe();
    op(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic rdchk(input string req, input logic [2:0] c, input logic [63:0] exp);
    rd_cls = c; #1;
    chk(req, rd_vec, exp);
  endtask

  task automatic selchk(input string req, input logic v, input logic [2:0] code);
    #1;
    chk(req, {sel_valid, sel_code}, {v, code});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R12 any_pend in reset", any_pend, 0);
    chk("R12 summary in reset", pend_sum, 0);
    selchk("R12 none in reset", 0, 3'd7);
    for (int c = 0; c < 8; c++) rdchk("R12 vector in reset", 3'(c), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_post_read();
    post(3, 63);
    post(0, 0);
    post(3, 10);
    rdchk("R1 class3 bits", 3, 64'h8000_0000_0000_0400);
    rdchk("R1 class0 bit0", 0, 64'h1);
    chk("R3 summary bits", pend_sum, 7'b0001001);
    chk("R3 any_pend", any_pend, 1);
    wipe();
  endtask

  task automatic t_clear_summary();
    post(5, 5); post(5, 9);
    clear(5, 5);
    rdchk("R2 remaining bit", 5, 64'h200);
    chk("R2 summary held", pend_sum[5], 1);
    clear(5, 9);
    chk("R2 summary dropped", pend_sum[5], 0);
    chk("R3 any_pend low", any_pend, 0);
  endtask

  task automatic t_clr_all();
    post(1, 3); post(6, 40);
    op(1, 2, 7, 0, 0, 0, 1);
    chk("R4 summary empty", pend_sum, 0);
    rdchk("R4 class2 not posted", 2, 0);
    rdchk("R4 class6 emptied", 6, 0);
  endtask

  task automatic t_user_order();
    hv_mode = 0; int_en = 0;
    post(6, 1); post(5, 2); post(4, 3); post(3, 4);
    selchk("R7 masked when disabled", 0, 3'd7);
    post(2, 0);
    selchk("R6 vector without enable", 1, 3'd2);
    post(1, 0);
    selchk("R6 hvtick over vector", 1, 3'd1);
    post(0, 0);
    selchk("R6 tlzero first", 1, 3'd0);
    int_en = 1;
    selchk("R6 tlzero with enable", 1, 3'd0);
    repeat (3) @(negedge clk);
    rdchk("R9 tlzero kept after select", 0, 64'h1);
    selchk("R9 still selected", 1, 3'd0);
    clear(0, 0); clear(1, 0); clear(2, 0);
    selchk("R7 xcpu", 1, 3'd3);
    clear(3, 4);
    selchk("R7 devmsg", 1, 3'd4);
    clear(4, 3);
    selchk("R7 soft", 1, 3'd5);
    clear(5, 2);
    selchk("R7 reserr", 1, 3'd6);
    wipe();
  endtask

  task automatic t_hv_order();
    for (int c = 0; c < 7; c++) post(3'(c), 6'(c));
    hv_mode = 1; int_en = 0;
    selchk("R5 gated without enable", 0, 3'd7);
    int_en = 1;
    selchk("R5 hvtick first", 1, 3'd1);
    clear(1, 1);
    selchk("R5 vector next", 1, 3'd2);
    clear(2, 2);
    selchk("R5 others ignored", 0, 3'd7);
    hv_mode = 0;
    wipe();
  endtask

  task automatic t_soft();
    post(5, 3);
    chk("R8 single bit", soft_lvl, 3);
    post(5, 12);
    chk("R8 highest bit", soft_lvl, 12);
    post(5, 0);
    chk("R8 bit0 alias", soft_lvl, 14);
    op(1, 5, 16, 1, 5, 0, 0);
    chk("R8 bit16 alias", soft_lvl, 14);
    op(1, 5, 15, 1, 5, 16, 0);
    chk("R8 bit15", soft_lvl, 15);
    wipe();
    post(5, 20);
    chk("R8 upper bits ignored", soft_lvl, 0);
    wipe();
  endtask

  task automatic t_collide();
    op(1, 4, 7, 1, 4, 7, 0);
    rdchk("R10 post wins same bit", 4, 64'h80);
    op(1, 4, 8, 1, 4, 7, 0);
    rdchk("R10 distinct bits same cycle", 4, 64'h100);
    chk("R2 summary after mixed op", pend_sum[4], 1);
    wipe();
  endtask

  task automatic t_bad_class();
    post(7, 1);
    chk("R11 post class7 ignored", any_pend, 0);
    rdchk("R11 class7 reads zero", 7, 0);
    post(2, 1);
    clear(7, 1);
    rdchk("R11 clear class7 ignored", 2, 64'h2);
    wipe();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    post_en = 0; clr_en = 0; clr_all = 0; hv_mode = 0; int_en = 0;
    post_cls = 0; post_idx = 0; clr_cls = 0; clr_idx = 0; rd_cls = 0;
    t_reset();
    t_post_read();
    t_clear_summary();
    t_clr_all();
    t_user_order();
    t_hv_order();
    t_soft();
    t_collide();
    t_bad_class();
    report();
  end
endmodule